// File: doc/BRIEF.md
# Clock-Adapting Bounded Buffer

This block links a producer and a consumer that run on different periodic activation patterns of one common clock. Each clock cycle is one instant. A high `wr_tick` marks a producer instant, and the word on `wr_data` is stored. A high `rd_tick` marks a consumer instant, and the oldest stored word is delivered. Occupancy is the running difference between accepted writes and served reads. The block does not choose a capacity. It stores up to `DEPTH` words in a circular memory and reports any instant at which the two patterns fail to fit that bound.

The `MODE` parameter picks the consumption rule:
- `CAB_PLAIN` lets a word written in an instant be read in that same instant, but only when nothing older is waiting.
- `CAB_STRICT` delays every word by at least one instant.
- `CAB_RELAY` acts like strict mode, except that the very first consumer instant delivers the constant `INIT_VALUE` and dequeues nothing.

Results of an instant appear on the outputs in the following cycle.

Top module: `clk_adapt_buf`

## Requirements
- R1: `level` equals the number of accepted writes minus the number of served reads since reset. It is updated in the cycle after each instant and never exceeds `DEPTH`.
- R2: A consumer instant that is served drives `rd_valid` high in the next cycle. Words come out in the order they were written. `rd_valid` is never high unless `rd_tick` was high one cycle earlier.
- R3: A write at an instant where `level` equals `DEPTH` and no read is served is dropped. It also sets `overflow`, which stays high until reset.
- R4: A write at an instant where `level` equals `DEPTH` and a read is served is accepted, and `level` stays at `DEPTH`.
- R5: A consumer instant with no word available delivers nothing (`rd_valid` low). It leaves `level` unchanged and sets `underflow`, which stays high until reset.
- R6: In `CAB_PLAIN`, a write and a read in the same instant on an empty buffer pass the written word straight to the output, and `level` stays 0.
- R7: In `CAB_STRICT`, a word is never readable in the instant it is written. A read on an empty buffer in a write instant underflows. A producer pattern 101010… against a consumer pattern 010101… keeps `level` at most 1 and delivers each word one instant after it entered. A producer pattern 100… against a consumer pattern 010… also runs without errors.
- R8: In `CAB_RELAY`, the first consumer instant after reset delivers `INIT_VALUE` (default 42) without dequeuing or underflowing. Later consumer instants follow the strict rule.
- R9: While `rst` is high, the block clears `level`, `overflow`, `underflow` and `rd_valid` at each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; one cycle is one instant |
| rst | input | 1 | Synchronous active-high reset |
| wr_tick | input | 1 | Producer instant |
| wr_data | input | WIDTH | Word written at a producer instant |
| rd_tick | input | 1 | Consumer instant |
| rd_valid | output | 1 | A word is delivered for the previous instant |
| rd_data | output | WIDTH | Delivered word, meaningful when `rd_valid` is high |
| level | output | LVL_W | Current occupancy |
| overflow | output | 1 | Sticky: a write was dropped on a full buffer |
| underflow | output | 1 | Sticky: a read found no word |

## Verification
All results of an instant are due exactly one clock edge after the instant is presented. This covers the delivered word, its valid bit, the new occupancy and both flags, in every mode, bypass included.

The driver applies each instant at the falling edge and queues one expected record for it. The monitor takes that record 5 ns after the next rising edge, which is the edge that makes the instant's results visible. Because there is exactly one record per cycle, the expected values never drift from the cycle in which they are due.

// File: rtl/cab_pkg.sv
package cab_pkg;
  typedef enum logic [1:0] {CAB_PLAIN, CAB_STRICT, CAB_RELAY} cab_mode_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_RAM, SRC_BYPASS, SRC_INIT} cab_src_e;
endpackage

// File: rtl/cab_ctrl.sv
module cab_ctrl #(
  parameter int DEPTH = 4,
  parameter cab_pkg::cab_mode_e MODE = cab_pkg::CAB_PLAIN,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_tick,
  input  logic              rd_tick,
  output logic              do_write,
  output logic [PW-1:0]     wr_ptr,
  output logic [PW-1:0]     rd_ptr,
  output cab_pkg::cab_src_e src,
  output logic [LW-1:0]     level,
  output logic              overflow,
  output logic              underflow
);
  import cab_pkg::*;

  localparam bit HOLD = (MODE != CAB_PLAIN);

  logic primed, init_emit, rd_req, empty, full, pop, bypass, miss, spill;

  generate
    if (MODE == CAB_RELAY) begin : g_relay
      always_ff @(posedge clk) begin
        if (rst)          primed <= 1'b0;
        else if (rd_tick) primed <= 1'b1;
      end
    end else begin : g_norelay
      assign primed = 1'b1;
    end
  endgenerate

  always_comb begin
    init_emit = rd_tick & ~primed;
    rd_req    = rd_tick & primed;
    empty     = (level == '0);
    full      = (level == LW'(DEPTH));
    pop       = rd_req & ~empty;
    bypass    = rd_req & empty & wr_tick & ~HOLD;
    miss      = rd_req & ~pop & ~bypass;
    do_write  = wr_tick & ~bypass & (~full | pop);
    spill     = wr_tick & ~bypass & full & ~pop;
    if (init_emit)   src = SRC_INIT;
    else if (pop)    src = SRC_RAM;
    else if (bypass) src = SRC_BYPASS;
    else             src = SRC_NONE;
  end

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (do_write) wr_ptr <= step_ptr(wr_ptr);
      if (pop)      rd_ptr <= step_ptr(rd_ptr);
      level     <= level + LW'(do_write) - LW'(pop);
      overflow  <= overflow | spill;
      underflow <= underflow | miss;
    end
  end
endmodule

// File: rtl/cab_ram.sv
module cab_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PW-1:0]    raddr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/cab_out.sv
module cab_out #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] INIT_VALUE = WIDTH'(42)
) (
  input  logic              clk,
  input  logic              rst,
  input  cab_pkg::cab_src_e src_in,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  ram_q,
  output logic              rd_valid,
  output logic [WIDTH-1:0]  rd_data
);
  import cab_pkg::*;

  cab_src_e         src_q;
  logic [WIDTH-1:0] byp_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= SRC_NONE;
    else     src_q <= src_in;
    byp_q <= wdata;
  end

  always_comb begin
    rd_valid = (src_q != SRC_NONE);
    case (src_q)
      SRC_RAM:    rd_data = ram_q;
      SRC_BYPASS: rd_data = byp_q;
      SRC_INIT:   rd_data = INIT_VALUE;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/clk_adapt_buf.sv
module clk_adapt_buf #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter cab_pkg::cab_mode_e MODE = cab_pkg::CAB_PLAIN,
  parameter logic [WIDTH-1:0] INIT_VALUE = WIDTH'(42),
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_tick,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_tick,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic [LVL_W-1:0] level,
  output logic             overflow,
  output logic             underflow
);
  logic              do_write;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [WIDTH-1:0]  ram_q;
  cab_pkg::cab_src_e src;

  cab_ctrl #(.DEPTH(DEPTH), .MODE(MODE)) u_ctrl (
    .clk(clk), .rst(rst), .wr_tick(wr_tick), .rd_tick(rd_tick),
    .do_write(do_write), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .src(src),
    .level(level), .overflow(overflow), .underflow(underflow)
  );

  cab_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(do_write), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .q(ram_q)
  );

  cab_out #(.WIDTH(WIDTH), .INIT_VALUE(INIT_VALUE)) u_out (
    .clk(clk), .rst(rst), .src_in(src), .wdata(wr_data), .ram_q(ram_q),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/cab_chk.sv
module cab_chk #(
  parameter int DEPTH = 4,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_tick,
  input logic          rd_tick,
  input logic          rd_valid,
  input logic [LW-1:0] level,
  input logic          overflow,
  input logic          underflow
);
  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  // R2
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_tick));

  // R3
  no_overflow_drop_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R3
  overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(wr_tick));

  // R5
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  // R5
  underflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(underflow) |-> $past(rd_tick));
endmodule

bind clk_adapt_buf cab_chk #(.DEPTH(DEPTH), .LW(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .wr_tick(wr_tick), .rd_tick(rd_tick),
  .rd_valid(rd_valid), .level(level), .overflow(overflow),
  .underflow(underflow)
);

// File: tb/sim_clk_adapt_buf.sv
`timescale 1ns/1ps
module sim_clk_adapt_buf;
  localparam int DEPTH = 4;

  typedef struct {
    bit         v[3];
    logic [7:0] d[3];
    int         lvl[3];
    bit         ov[3];
    bit         un[3];
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_tick = 1'b0, rd_tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rvld [3];
  logic [7:0] rdat [3];
  logic [2:0] lvl  [3];
  logic       ovf  [3];
  logic       unf  [3];

  int compared = 0, mismatched = 0;
  bit done = 0;

  exp_t       expq[$];
  logic [7:0] mq [3][$];
  bit         m_ovf [3];
  bit         m_unf [3];
  bit         m_primed [3];

  always #10 clk = ~clk;

  clk_adapt_buf #(.WIDTH(8), .DEPTH(DEPTH), .MODE(cab_pkg::CAB_PLAIN)) u0 (
    .clk(clk), .rst(rst), .wr_tick(wr_tick), .wr_data(wr_data), .rd_tick(rd_tick),
    .rd_valid(rvld[0]), .rd_data(rdat[0]), .level(lvl[0]),
    .overflow(ovf[0]), .underflow(unf[0]));
  clk_adapt_buf #(.WIDTH(8), .DEPTH(DEPTH), .MODE(cab_pkg::CAB_STRICT)) u1 (
    .clk(clk), .rst(rst), .wr_tick(wr_tick), .wr_data(wr_data), .rd_tick(rd_tick),
    .rd_valid(rvld[1]), .rd_data(rdat[1]), .level(lvl[1]),
    .overflow(ovf[1]), .underflow(unf[1]));
  clk_adapt_buf #(.WIDTH(8), .DEPTH(DEPTH), .MODE(cab_pkg::CAB_RELAY)) u2 (
    .clk(clk), .rst(rst), .wr_tick(wr_tick), .wr_data(wr_data), .rd_tick(rd_tick),
    .rd_valid(rvld[2]), .rd_data(rdat[2]), .level(lvl[2]),
    .overflow(ovf[2]), .underflow(unf[2]));

  task automatic check(input bit ok, input string tag, input string what,
                       input int m, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s mode%0d %s: actual %0d expected %0d", tag, m, what, act, exp);
    end
  endtask

  // R9: reset applied for one instant, all outputs expected cleared
  task automatic do_reset();
    exp_t e;
    @(negedge clk);
    rst = 1'b1; wr_tick = 1'b0; rd_tick = 1'b0; wr_data = '0;
    for (int m = 0; m < 3; m++) begin
      mq[m].delete();
      m_ovf[m] = 0; m_unf[m] = 0; m_primed[m] = 0;
      e.v[m] = 0; e.d[m] = '0; e.lvl[m] = 0; e.ov[m] = 0; e.un[m] = 0;
    end
    e.tag = "R9";
    expq.push_back(e);
  endtask

  task automatic step(input bit w, input logic [7:0] d, input bit r, input string tag);
    exp_t e;
    @(negedge clk);
    rst = 1'b0; wr_tick = w; rd_tick = r; wr_data = d;
    for (int m = 0; m < 3; m++) begin
      automatic bit hold = (m != 0);
      automatic bit byp = 0;
      e.v[m] = 0; e.d[m] = '0;
      if (r && m == 2 && !m_primed[m]) begin
        m_primed[m] = 1; e.v[m] = 1; e.d[m] = 8'd42;
      end else if (r) begin
        if (m == 2) m_primed[m] = 1;
        if (mq[m].size() > 0) begin
          e.v[m] = 1; e.d[m] = mq[m].pop_front();
        end else if (w && !hold) begin
          e.v[m] = 1; e.d[m] = d; byp = 1;
        end else begin
          m_unf[m] = 1;
        end
      end
      if (w && !byp) begin
        if (mq[m].size() < DEPTH) mq[m].push_back(d);
        else m_ovf[m] = 1;
      end
      e.lvl[m] = mq[m].size(); e.ov[m] = m_ovf[m]; e.un[m] = m_unf[m];
    end
    e.tag = tag;
    expq.push_back(e);
  endtask

  // monitor: one record per instant, due one edge later
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expq.size() > 0) begin
        automatic exp_t e = expq.pop_front();
        for (int m = 0; m < 3; m++) begin
          check(rvld[m] === e.v[m], e.tag, "rd_valid", m, int'(rvld[m]), int'(e.v[m]));
          if (e.v[m])
            check(rdat[m] === e.d[m], e.tag, "rd_data", m, int'(rdat[m]), int'(e.d[m]));
          check(int'(lvl[m]) == e.lvl[m], e.tag, "level", m, int'(lvl[m]), e.lvl[m]);
          check(ovf[m] === e.ov[m], e.tag, "overflow", m, int'(ovf[m]), int'(e.ov[m]));
          check(unf[m] === e.un[m], e.tag, "underflow", m, int'(unf[m]), int'(e.un[m]));
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    // R9 reset state
    do_reset();
    // R2 / R7: producer 101010 against consumer 010101
    for (int i = 0; i < 12; i++) step(i % 2 == 0, 8'(10 + i), i % 2 == 1, "R2");
    // R6: same-instant write and read on an empty buffer
    do_reset();
    step(1, 8'h55, 1, "R6");
    step(0, 8'h00, 1, "R6");
    step(0, 8'h00, 1, "R6");
    // R1 fill, R4 full with read, R3 full without read
    do_reset();
    for (int i = 0; i < 4; i++) step(1, 8'(100 + i), 0, "R1");
    step(1, 8'd120, 1, "R4");
    step(1, 8'd121, 0, "R3");
    step(0, 8'd0, 0, "R3");
    for (int i = 0; i < 6; i++) step(0, 8'd0, 1, "R2");
    // R5: read on empty, flag stays set afterwards
    do_reset();
    step(0, 8'd0, 0, "R5");
    step(0, 8'd0, 1, "R5");
    step(1, 8'd77, 0, "R5");
    step(0, 8'd0, 1, "R5");
    step(0, 8'd0, 1, "R5");
    step(0, 8'd0, 0, "R5");
    // R7: producer 100 against consumer 010
    do_reset();
    for (int i = 0; i < 12; i++) step(i % 3 == 0, 8'(200 + i), i % 3 == 1, "R7");
    // R8: first consumer instant alone
    do_reset();
    step(0, 8'd0, 1, "R8");
    step(1, 8'd9, 0, "R8");
    step(0, 8'd0, 1, "R8");
    step(0, 8'd0, 0, "R8");
    @(posedge clk);
    #8;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule